// File: doc/BRIEF.md
# Host-Target Mailbox Register Interface

A processor talks to a host through two 64-bit mailbox registers: a to-host register that carries commands and a from-host register that carries replies. The processor reaches each one as two 32-bit words on a simple single-cycle register bus. A command is built with a low-word write followed by a high-word write. The high-word write completes the 64-bit word and starts a fixed decode. The top byte selects a device, the next byte selects a command, and the remaining 48 bits are the payload.

Two devices are served. Device 0 reports test completion: it raises an exit request that carries an exit code. Device 1 is a byte console. One of its commands sends a byte out over a valid/ready stream. Another registers a read request, and a later input byte answers that request through the from-host register. Every reply keeps the top 16 bits of the command (device and command) and places a response value in the low bits. The two register offsets are parameters.

Top module: `hostlink_mailbox`

## Requirements
- R1: After reset, both mailbox registers read zero on all four slots, `cons_out_valid` is low and `exit_valid` is low.
- R2: Each register is exposed as a low slot at its base offset (bits 31:0) and a high slot at base+4 (bits 63:32). Any other address reads zero, and a write to it changes no register.
- R3: A to-host low write stores the data in bits 31:0 and arms the high write, but only while the whole to-host register is zero. When to-host is nonzero, the write leaves to-host unchanged and disarms the high write.
- R4: A to-host high write has an effect only while armed. It then ORs the data into bits 63:32 and processes the completed word, with device = bits 63:56, command = bits 55:48 and payload = bits 47:0. An unarmed high write leaves to-host unchanged.
- R5: For device 0, command 0 with payload bit 0 set, `exit_valid` pulses for one cycle with `exit_code` = payload >> 1. With payload bit 0 clear, no exit is raised. In both cases from-host becomes {word[63:48], 48'h0} and to-host becomes zero.
- R6: For device 1, command 1, `cons_out_valid` rises with `cons_out_data` = payload[7:0]. When the byte is accepted, from-host becomes {word[63:48], 48'h100 | byte} and to-host becomes zero.
- R7: While a console output byte waits for `cons_out_ready`, to-host keeps the command word, from-host is unchanged, `cons_out_data` is stable, and further to-host writes have no effect.
- R8: For device 1, command 0, the command word is saved as the pending read request and to-host becomes zero. From-host is not written.
- R9: A cycle with `cons_in_valid` high loads from-host with {pending[63:48], 48'h100 | byte}.
- R10: Any other device/command pair loads from-host with {word[63:48], 48'h0} and clears to-host.
- R11: A from-host low write loads the register with the zero-extended data and sets the in-progress flag. A from-host high write ORs the data into bits 63:32 and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the 32-bit slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the request |
| cons_out_valid | output | 1 | Console output byte available |
| cons_out_ready | input | 1 | Console sink accepts the byte |
| cons_out_data | output | 8 | Console output byte |
| cons_in_valid | input | 1 | Console input byte strobe |
| cons_in_data | input | 8 | Console input byte |
| exit_valid | output | 1 | One-cycle exit request |
| exit_code | output | 47 | Exit code carried with the request |

## Verification
The bench builds the block with an 8-bit address, the to-host register at 0x40 and the from-host register at 0x10. This places the reply register below the command register, so the slot decode cannot depend on any ordering between the two offsets. The bench also uses address 0x20, which falls between the two registers, as an unmapped probe. Holding `cons_out_ready` low for several cycles brings the output stall, and the bus writes attempted during it, within reach. A reset in the middle of the run recovers from the stuck, nonzero to-host state that a rejected low write leaves behind.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  localparam int WORD_W    = 64;
  localparam int HALF_W    = 32;
  localparam int PAYLOAD_W = 48;
  localparam int EXIT_W    = PAYLOAD_W - 1;
  localparam int RESP_W    = 9;

  localparam logic [7:0] DEV_SYS  = 8'd0;
  localparam logic [7:0] DEV_CONS = 8'd1;
  localparam logic [7:0] CMD_SYS_EXIT  = 8'd0;
  localparam logic [7:0] CMD_CONS_GET  = 8'd0;
  localparam logic [7:0] CMD_CONS_PUT  = 8'd1;

  typedef enum logic [2:0] {
    ACT_EXIT,
    ACT_UNSUP,
    ACT_PUTC,
    ACT_GETREQ,
    ACT_UNKNOWN
  } mb_act_e;

  function automatic logic [7:0] mb_dev(input logic [WORD_W-1:0] w);
    return w[63:56];
  endfunction

  function automatic logic [7:0] mb_cmd(input logic [WORD_W-1:0] w);
    return w[55:48];
  endfunction

  function automatic logic [PAYLOAD_W-1:0] mb_payload(input logic [WORD_W-1:0] w);
    return w[PAYLOAD_W-1:0];
  endfunction

  // Reply keeps device/command of the source word, response in the low bits.
  function automatic logic [WORD_W-1:0] mb_reply(input logic [WORD_W-1:0] src,
                                                 input logic [RESP_W-1:0] resp);
    return {src[63:48], {(PAYLOAD_W-RESP_W){1'b0}}, resp};
  endfunction

  function automatic logic [RESP_W-1:0] mb_cons_resp(input logic [7:0] b);
    return {1'b1, b};
  endfunction
endpackage

// File: rtl/hostlink_addr_dec.sv
module hostlink_addr_dec #(
  parameter int unsigned          ADDR_W       = 12,
  parameter logic [ADDR_W-1:0]    TOHOST_OFS   = '0,
  parameter logic [ADDR_W-1:0]    FROMHOST_OFS = ADDR_W'(8)
) (
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       tohost,
  input  logic [63:0]       fromhost,
  output logic              th_lo_wr,
  output logic              th_hi_wr,
  output logic              fh_lo_wr,
  output logic              fh_hi_wr,
  output logic [31:0]       rdata
);
  localparam int NSLOT = 4;
  // slot order: to-host lo, to-host hi, from-host lo, from-host hi
  logic [NSLOT-1:0] hit;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] BASE = (g < 2) ? TOHOST_OFS : FROMHOST_OFS;
    localparam logic [ADDR_W-1:0] OFS  = BASE + ADDR_W'((g % 2) * 4);
    assign hit[g] = bus_req && (bus_addr == OFS);
  end

  assign th_lo_wr = hit[0] && bus_we;
  assign th_hi_wr = hit[1] && bus_we;
  assign fh_lo_wr = hit[2] && bus_we;
  assign fh_hi_wr = hit[3] && bus_we;

  always_comb begin
    rdata = '0;
    if (hit[0])      rdata = tohost[31:0];
    else if (hit[1]) rdata = tohost[63:32];
    else if (hit[2]) rdata = fromhost[31:0];
    else if (hit[3]) rdata = fromhost[63:32];
  end
endmodule

// File: rtl/hostlink_cmd_dec.sv
module hostlink_cmd_dec
  import hostlink_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output mb_act_e           act
);
  logic [7:0] dev, cmd;
  logic       exit_flag;

  assign dev       = mb_dev(word);
  assign cmd       = mb_cmd(word);
  assign exit_flag = word[0];

  always_comb begin
    act = ACT_UNKNOWN;
    if (dev == DEV_SYS && cmd == CMD_SYS_EXIT)
      act = exit_flag ? ACT_EXIT : ACT_UNSUP;
    else if (dev == DEV_CONS && cmd == CMD_CONS_PUT)
      act = ACT_PUTC;
    else if (dev == DEV_CONS && cmd == CMD_CONS_GET)
      act = ACT_GETREQ;
  end
endmodule

// File: rtl/hostlink_mailbox.sv
module hostlink_mailbox
  import hostlink_pkg::*;
#(
  parameter int unsigned       ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] TOHOST_OFS   = '0,
  parameter logic [ADDR_W-1:0] FROMHOST_OFS = ADDR_W'(8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cons_out_valid,
  input  logic              cons_out_ready,
  output logic [7:0]        cons_out_data,
  input  logic              cons_in_valid,
  input  logic [7:0]        cons_in_data,
  output logic              exit_valid,
  output logic [EXIT_W-1:0] exit_code
);
  logic [WORD_W-1:0] tohost_q, fromhost_q, pending_q;
  logic              allow_q, inprog_q, wait_q;
  logic              exit_valid_q;
  logic [EXIT_W-1:0] exit_code_q;

  logic th_lo_wr, th_hi_wr, fh_lo_wr, fh_hi_wr;

  hostlink_addr_dec #(
    .ADDR_W(ADDR_W), .TOHOST_OFS(TOHOST_OFS), .FROMHOST_OFS(FROMHOST_OFS)
  ) u_addr (
    .bus_req (bus_req),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .tohost  (tohost_q),
    .fromhost(fromhost_q),
    .th_lo_wr(th_lo_wr),
    .th_hi_wr(th_hi_wr),
    .fh_lo_wr(fh_lo_wr),
    .fh_hi_wr(fh_hi_wr),
    .rdata   (bus_rdata)
  );

  // Completed command word as seen during the high-word write.
  logic [WORD_W-1:0] word_done;
  mb_act_e           act;
  logic              cmd_go, out_fire, tohost_empty;

  assign word_done    = {tohost_q[63:32] | bus_wdata, tohost_q[31:0]};
  assign cmd_go       = th_hi_wr && allow_q && !wait_q;
  assign out_fire     = wait_q && cons_out_ready;
  assign tohost_empty = (tohost_q == '0);

  hostlink_cmd_dec u_cmd (
    .word(word_done),
    .act (act)
  );

  // Reply selection: an immediate reply and an output completion never coincide.
  logic              reply_en;
  logic [WORD_W-1:0] reply_val;

  always_comb begin
    reply_en  = 1'b0;
    reply_val = '0;
    if (cmd_go && (act == ACT_EXIT || act == ACT_UNSUP || act == ACT_UNKNOWN)) begin
      reply_en  = 1'b1;
      reply_val = mb_reply(word_done, '0);
    end else if (out_fire) begin
      reply_en  = 1'b1;
      reply_val = mb_reply(tohost_q, mb_cons_resp(tohost_q[7:0]));
    end
  end

  // To-host register, arm flag, pending request, exit request.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tohost_q     <= '0;
      allow_q      <= 1'b0;
      wait_q       <= 1'b0;
      pending_q    <= '0;
      exit_valid_q <= 1'b0;
      exit_code_q  <= '0;
    end else begin
      exit_valid_q <= 1'b0;
      if (th_lo_wr) begin
        if (tohost_empty) begin
          tohost_q[31:0] <= bus_wdata;
          allow_q        <= 1'b1;
        end else begin
          allow_q <= 1'b0;
        end
      end
      if (cmd_go) begin
        case (act)
          ACT_EXIT: begin
            exit_valid_q <= 1'b1;
            exit_code_q  <= mb_payload(word_done)[PAYLOAD_W-1:1];
            tohost_q     <= '0;
          end
          ACT_PUTC: begin
            tohost_q <= word_done;
            wait_q   <= 1'b1;
          end
          ACT_GETREQ: begin
            pending_q <= word_done;
            tohost_q  <= '0;
          end
          default: tohost_q <= '0;
        endcase
      end
      if (out_fire) begin
        wait_q   <= 1'b0;
        tohost_q <= '0;
      end
    end
  end

  // From-host register: bus write, then command reply, then console input.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fromhost_q <= '0;
      inprog_q   <= 1'b0;
    end else if (fh_lo_wr) begin
      fromhost_q <= {{HALF_W{1'b0}}, bus_wdata};
      inprog_q   <= 1'b1;
    end else if (fh_hi_wr) begin
      fromhost_q[63:32] <= fromhost_q[63:32] | bus_wdata;
      inprog_q          <= 1'b0;
    end else if (reply_en) begin
      fromhost_q <= reply_val;
    end else if (cons_in_valid) begin
      fromhost_q <= mb_reply(pending_q, mb_cons_resp(cons_in_data));
    end
  end

  assign cons_out_valid = wait_q;
  assign cons_out_data  = tohost_q[7:0];
  assign exit_valid     = exit_valid_q;
  assign exit_code      = exit_code_q;
endmodule

// File: rtl/hostlink_mailbox_chk.sv
module hostlink_mailbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cons_out_valid,
  input logic        cons_out_ready,
  input logic [7:0]  cons_out_data,
  input logic        exit_valid,
  input logic [63:0] tohost_q,
  input logic        inprog_q,
  input logic        th_lo_wr,
  input logic        fh_lo_wr,
  input logic        fh_hi_wr
);
  // R5: exit request lasts exactly one cycle
  p_exit_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |=> !exit_valid);

  // R7: a waiting byte stays offered and unchanged
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cons_out_valid && !cons_out_ready |=> cons_out_valid && $stable(cons_out_data));

  // R6: acceptance completes the command and empties to-host
  p_out_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cons_out_valid && cons_out_ready |=> !cons_out_valid && tohost_q == 64'd0);

  // R3: low write into an occupied to-host leaves it untouched
  p_lo_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    th_lo_wr && tohost_q != 64'd0 && !cons_out_valid |=> tohost_q == $past(tohost_q));

  // R11: in-progress flag follows the from-host half writes
  p_fh_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fh_lo_wr |=> inprog_q);
  p_fh_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fh_hi_wr |=> !inprog_q);
endmodule

bind hostlink_mailbox hostlink_mailbox_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cons_out_valid(cons_out_valid),
  .cons_out_ready(cons_out_ready),
  .cons_out_data (cons_out_data),
  .exit_valid    (exit_valid),
  .tohost_q      (tohost_q),
  .inprog_q      (inprog_q),
  .th_lo_wr      (th_lo_wr),
  .fh_lo_wr      (fh_lo_wr),
  .fh_hi_wr      (fh_hi_wr)
);

// File: tb/hostlink_mailbox_tb_top.sv
module hostlink_mailbox_tb_top;
  localparam int          AW  = 8;
  localparam logic [7:0]  TH  = 8'h40;
  localparam logic [7:0]  FH  = 8'h10;
  localparam logic [7:0]  BAD = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        cons_out_valid, cons_out_ready = 1'b1;
  logic [7:0]  cons_out_data;
  logic        cons_in_valid = 1'b0;
  logic [7:0]  cons_in_data = '0;
  logic        exit_valid;
  logic [46:0] exit_code;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  exp_out_q[$];
  logic [46:0] exp_exit_q[$];

  always #2 clk = ~clk;

  hostlink_mailbox #(.ADDR_W(AW), .TOHOST_OFS(TH), .FROMHOST_OFS(FH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cons_out_valid(cons_out_valid), .cons_out_ready(cons_out_ready),
    .cons_out_data(cons_out_data), .cons_in_valid(cons_in_valid),
    .cons_in_data(cons_in_data), .exit_valid(exit_valid), .exit_code(exit_code)
  );

  function automatic logic [63:0] reply_of(input logic [63:0] w, input logic [15:0] resp);
    return (w & 64'hFFFF_0000_0000_0000) | {48'd0, resp};
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic read64(input logic [7:0] base, output logic [63:0] v);
    logic [31:0] lo, hi;
    bus_read(base, lo);
    bus_read(base + 8'd4, hi);
    v = {hi, lo};
  endtask

  task automatic send_cmd(input logic [63:0] w);
    bus_write(TH, w[31:0]);
    bus_write(TH + 8'd4, w[63:32]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  // Monitor: pop expected console bytes and exit codes as they appear.
  always @(negedge clk) begin
    if (rst_n && cons_out_valid && cons_out_ready) begin
      checks++;
      if (exp_out_q.size() == 0) begin
        errors++;
        $display("FAIL R6: actual byte %h expected none", cons_out_data);
      end else begin
        logic [7:0] e;
        e = exp_out_q.pop_front();
        if (cons_out_data !== e) begin
          errors++;
          $display("FAIL R6: actual byte %h expected %h", cons_out_data, e);
        end
      end
    end
    if (rst_n && exit_valid) begin
      checks++;
      if (exp_exit_q.size() == 0) begin
        errors++;
        $display("FAIL R5: actual exit %h expected none", exit_code);
      end else begin
        logic [46:0] e;
        e = exp_exit_q.pop_front();
        if (exit_code !== e) begin
          errors++;
          $display("FAIL R5: actual exit %h expected %h", exit_code, e);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, fh_prev, w;
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    read64(TH, v); check64("R1 tohost", v, 64'd0);
    read64(FH, v); check64("R1 fromhost", v, 64'd0);
    check64("R1 outputs", {62'd0, cons_out_valid, exit_valid}, 64'd0);

    // R2 unmapped address
    bus_write(BAD, 32'hA5A5_A5A5);
    bus_read(BAD, d); check64("R2 unmapped read", {32'd0, d}, 64'd0);
    read64(TH, v); check64("R2 tohost untouched", v, 64'd0);
    read64(FH, v); check64("R2 fromhost untouched", v, 64'd0);

    // R4 unarmed high write
    bus_write(TH + 8'd4, 32'h0101_0000);
    idle(2);
    read64(TH, v); check64("R4 unarmed high", v, 64'd0);

    // R2/R5 exit with code; halves read back before the high write
    w = {8'h00, 8'h00, 48'h1578_2468_ACF3};
    bus_write(TH, w[31:0]);
    bus_read(TH, d); check64("R2 low slot", {32'd0, d}, {32'd0, w[31:0]});
    bus_read(TH + 8'd4, d); check64("R2 high slot", {32'd0, d}, 64'd0);
    exp_exit_q.push_back(w[47:1]);
    bus_write(TH + 8'd4, w[63:32]);
    idle(3);
    read64(FH, v); check64("R5 exit reply", v, reply_of(w, 16'h0));
    read64(TH, v); check64("R5 tohost cleared", v, 64'd0);
    check64("R5 exit consumed", exp_exit_q.size(), 0);

    // R5 unsupported (payload bit 0 clear): reply overwrites from-host
    bus_write(FH, 32'h0000_DEAD);
    send_cmd({8'h00, 8'h00, 48'h0000_0000_0010});
    idle(3);
    read64(FH, v); check64("R5 no-exit reply", v, 64'd0);

    // R6 console output with ready high
    w = {8'h01, 8'h01, 48'h0000_0000_0041};
    exp_out_q.push_back(8'h41);
    send_cmd(w);
    idle(3);
    read64(FH, v); check64("R6 putc reply", v, reply_of(w, 16'h0141));
    read64(TH, v); check64("R6 tohost cleared", v, 64'd0);
    fh_prev = reply_of(w, 16'h0141);

    // R7 stall while ready is low
    cons_out_ready = 1'b0;
    w = {8'h01, 8'h01, 48'hABCD_1234_565A};
    send_cmd(w);
    idle(6);
    check64("R7 valid held", {56'd0, cons_out_valid, cons_out_data}, {56'd0, 1'b1, 8'h5A});
    read64(TH, v); check64("R7 tohost held", v, w);
    read64(FH, v); check64("R7 fromhost unchanged", v, fh_prev);
    bus_write(TH + 8'd4, 32'hFFFF_0000);
    bus_write(TH, 32'h0000_0001);
    read64(TH, v); check64("R7 writes ignored", v, w);
    exp_out_q.push_back(8'h5A);
    @(negedge clk); cons_out_ready = 1'b1;
    idle(3);
    read64(FH, v); check64("R7 reply after accept", v, reply_of(w, 16'h015A));
    read64(TH, v); check64("R7 tohost cleared", v, 64'd0);

    // R10 unknown device and unknown console command
    w = {8'h05, 8'h03, 48'h0000_0000_0001};
    send_cmd(w); idle(3);
    read64(FH, v); check64("R10 unknown device", v, reply_of(w, 16'h0));
    w = {8'h01, 8'h02, 48'h0000_0000_0077};
    send_cmd(w); idle(3);
    read64(FH, v); check64("R10 unknown command", v, reply_of(w, 16'h0));
    read64(TH, v); check64("R10 tohost cleared", v, 64'd0);
    fh_prev = reply_of(w, 16'h0);

    // R8 read request then R9 input bytes
    w = {8'h01, 8'h00, 48'h0000_0000_0000};
    send_cmd(w); idle(3);
    read64(FH, v); check64("R8 no reply", v, fh_prev);
    read64(TH, v); check64("R8 tohost cleared", v, 64'd0);
    @(negedge clk); cons_in_valid = 1'b1; cons_in_data = 8'h37;
    @(negedge clk); cons_in_valid = 1'b0;
    idle(1);
    read64(FH, v); check64("R9 input byte", v, reply_of(w, 16'h0137));
    @(negedge clk); cons_in_valid = 1'b1; cons_in_data = 8'h0A;
    @(negedge clk); cons_in_valid = 1'b0;
    idle(1);
    read64(FH, v); check64("R9 second byte", v, reply_of(w, 16'h010A));

    // R11 from-host half writes
    bus_write(FH + 8'd4, 32'hFFFF_0000);
    bus_write(FH, 32'h0000_0001);
    read64(FH, v); check64("R11 low zero-extends", v, 64'h0000_0000_0000_0001);
    bus_write(FH + 8'd4, 32'h00A0_0000);
    bus_write(FH + 8'd4, 32'h0000_0005);
    read64(FH, v); check64("R11 high ORs", v, 64'h00A0_0005_0000_0001);

    // R3 rejected low write disarms the high write
    bus_write(TH, 32'h0000_0011);
    bus_write(TH, 32'h0000_0022);
    read64(TH, v); check64("R3 low rejected", v, 64'h0000_0000_0000_0011);
    bus_write(TH + 8'd4, 32'h0101_0000);
    idle(2);
    read64(TH, v); check64("R3 high disarmed", v, 64'h0000_0000_0000_0011);
    check64("R3 no output", {63'd0, cons_out_valid}, 64'd0);

    do_reset();
    idle(1);
    read64(TH, v); check64("R1 after reset", v, 64'd0);

    check64("R6 queue drained", exp_out_q.size(), 0);
    check64("R5 queue drained", exp_exit_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule